// File: doc/BRIEF.md
# Capability load revocation filter

This block sits on the return path of a capability-load instruction and decides whether the tag that travels with the loaded 64-bit capability may stay set. It owns a bitmap with one revocation flag per 8-byte granule of heap RAM. When the allocator frees a region, it marks the matching granules through a privileged write port. Once a background sweep has finished, it clears them again so the memory can be reused.

Each load response enters with its data, its memory tag and a flag saying whether it was a capability load. For capability loads, the block reads the address field of the capability and finds the granule flag for the heap location it points at. If that flag is set, the tag is dropped. Every response leaves exactly one cycle later, with the data unchanged. Plain data loads never consult the bitmap.

Top module: `cap_revoke_filter`

## Requirements
- R1: After reset every granule flag reads as clear, so a capability load with tag 1 pointing anywhere in the heap leaves with tag 1; while reset is held, outValid and outTag are 0.
- R2: A response presented with rspValid=1 in cycle n appears on the outputs in cycle n+1 with outData equal to rspData and outIsCap equal to rspIsCap; the pointed-to address is rspData[31:0].
- R3: A capability load (rspIsCap=1) with tag 1 whose address lies in the heap window and whose granule flag is 1 leaves with outTag 0.
- R4: A response whose incoming tag is 0 always leaves with outTag 0.
- R5: A response with rspIsCap=0 leaves with outTag equal to rspTag, whatever the flag of the granule its low word points at.
- R6: An address below HEAP_BASE or at or above HEAP_BASE+HEAP_BYTES is never treated as revoked: outTag equals rspTag.
- R7: The granule index is (address - HEAP_BASE) >> 3, so all eight bytes of one granule share one flag and the neighbouring granules are unaffected.
- R8: A write with allocWrPriv=0 changes no flag.
- R9: A privileged write with allocWrVal=0 clears a flag, and later capability loads into that granule keep their tag.
- R10: A privileged write to the granule that a capability load looks up in the same cycle is seen by that load (write first).
- R11: outValid is rspValid delayed by one cycle, and outTag is 0 whenever outValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocWrEn | input | 1 | Allocator bitmap write request |
| allocWrPriv | input | 1 | Write carries allocator privilege; without it the write is dropped |
| allocWrIdx | input | IDX_W (9) | Granule index to write |
| allocWrVal | input | 1 | New flag value, 1 = revoked |
| rspValid | input | 1 | Load response present |
| rspIsCap | input | 1 | Response belongs to a capability load |
| rspData | input | 64 | Loaded data; bits [31:0] hold the capability address |
| rspTag | input | 1 | Memory tag of the loaded word |
| outValid | output | 1 | Filtered response present |
| outIsCap | output | 1 | Delayed capability-load flag |
| outData | output | 64 | Delayed data, unchanged |
| outTag | output | 1 | Final tag for the destination register |

## Verification
A bitmap flag that holds the wrong value stays hidden until a capability load points into that granule. The next cycle, it shows as a tag that was wrongly kept or wrongly dropped. A fault in the index arithmetic or in the window limits shows up the same way, but only when the load lands on a granule whose flag differs from the one actually read. The bench therefore mixes writes and loads aimed at the same and at adjacent granules. It also includes addresses just outside the window that would alias onto marked granules if the window test were missing. A broken forwarding path only shows when a write and a load meet on one granule in one cycle, and that case is driven on purpose.

// File: rtl/revoke_pkg.sv
package revoke_pkg;

  // Strobes the control issues to the datapath each cycle.
  typedef struct packed {
    logic wrEn;    // privileged, in-range bitmap write
    logic wrVal;   // value to write
    logic lookEn;  // capability load inside the heap window
    logic inWin;   // pointed-to address lies inside the heap window
    logic fwdHit;  // write and lookup target the same granule
  } revStrobe_t;

endpackage

// File: rtl/revoke_ctrl.sv
module revoke_ctrl
  import revoke_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] HEAP_BASE  = 32'h2000_0000,
  parameter int                HEAP_BYTES = 4096,
  parameter int                GRAN_LG    = 3,
  parameter int                GRANULES   = HEAP_BYTES >> GRAN_LG,
  parameter int                IDX_W      = $clog2(GRANULES)
) (
  input  logic              allocWrEn,
  input  logic              allocWrPriv,
  input  logic [IDX_W-1:0]  allocWrIdx,
  input  logic              allocWrVal,
  input  logic              rspValid,
  input  logic              rspIsCap,
  input  logic [ADDR_W-1:0] rspAddr,
  output revStrobe_t        strobe,
  output logic [IDX_W-1:0]  lookIdx,
  output logic [IDX_W-1:0]  wrIdx
);

  localparam logic [ADDR_W:0] BASE_EXT  = {1'b0, HEAP_BASE};
  localparam logic [ADDR_W:0] LIMIT_EXT = BASE_EXT + (ADDR_W+1)'(HEAP_BYTES);
  localparam logic [IDX_W:0]  GRAN_CNT  = (IDX_W+1)'(GRANULES);

  logic [ADDR_W:0] addrExt;
  logic [ADDR_W:0] offset;
  logic            inWin;
  logic            wrOk;
  logic            lookOk;

  // Heap window test and granule index derivation.
  always_comb begin
    addrExt = {1'b0, rspAddr};
    offset  = addrExt - BASE_EXT;
    inWin   = (addrExt >= BASE_EXT) && (addrExt < LIMIT_EXT);
    lookIdx = offset[GRAN_LG +: IDX_W];
  end

  // Write gating: privilege and index range.
  always_comb begin
    wrIdx  = allocWrIdx;
    wrOk   = allocWrEn && allocWrPriv && ({1'b0, allocWrIdx} < GRAN_CNT);
    lookOk = rspValid && rspIsCap && inWin;
  end

  always_comb begin
    strobe.wrEn   = wrOk;
    strobe.wrVal  = allocWrVal;
    strobe.lookEn = lookOk;
    strobe.inWin  = inWin;
    strobe.fwdHit = wrOk && lookOk && (allocWrIdx == lookIdx);
  end

endmodule

// File: rtl/revoke_datapath.sv
module revoke_datapath
  import revoke_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int GRANULES = 512,
  parameter int IDX_W    = $clog2(GRANULES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  revStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  lookIdx,
  input  logic              rspValid,
  input  logic              rspIsCap,
  input  logic [DATA_W-1:0] rspData,
  input  logic              rspTag,
  output logic              outValid,
  output logic              outIsCap,
  output logic [DATA_W-1:0] outData,
  output logic              outTag
);

  logic [GRANULES-1:0] revMap;
  logic                hitQ;
  logic                validQ;
  logic                isCapQ;
  logic                tagQ;
  logic [DATA_W-1:0]   dataQ;
  logic                lookBit;

  // One flop per granule flag, each with its own write decode.
  for (genvar g = 0; g < GRANULES; g++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        revMap[g] <= 1'b0;
      end else if (strobe.wrEn && (wrIdx == IDX_W'(g))) begin
        revMap[g] <= strobe.wrVal;
      end
    end
  end

  // Write-first: a same-cycle write to the looked-up granule wins.
  always_comb begin
    lookBit = strobe.fwdHit ? strobe.wrVal : revMap[lookIdx];
  end

  // Lookup result and matching delay stage for the response.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ   <= 1'b0;
      validQ <= 1'b0;
      isCapQ <= 1'b0;
      tagQ   <= 1'b0;
      dataQ  <= '0;
    end else begin
      validQ <= rspValid;
      hitQ   <= strobe.lookEn && lookBit;
      if (rspValid) begin
        isCapQ <= rspIsCap;
        tagQ   <= rspTag;
        dataQ  <= rspData;
      end
    end
  end

  always_comb begin
    outValid = validQ;
    outIsCap = isCapQ;
    outData  = dataQ;
    outTag   = validQ && tagQ && !hitQ;
  end

  // R11: output valid trails input valid by one cycle
  a_r11_valid_delay: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> outValid);
  a_r11_idle_delay: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |=> (!outValid && !outTag));
  // R2: data leaves unchanged one cycle later
  a_r2_data_pass: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (outData == $past(rspData)) && (outIsCap == $past(rspIsCap)));
  // R4: a tag is never created
  a_r4_no_tag_create: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspTag) |=> !outTag);
  // R5: plain loads keep their tag
  a_r5_plain_pass: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspIsCap) |=> (outTag == $past(rspTag)));
  // R6: addresses outside the window are never revoked
  a_r6_out_window: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !strobe.inWin) |=> (outTag == $past(rspTag)));
  // R8: no accepted write, no bitmap change
  a_r8_map_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(revMap));

endmodule

// File: rtl/cap_revoke_filter.sv
module cap_revoke_filter
  import revoke_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 64,
  parameter logic [ADDR_W-1:0] HEAP_BASE  = 32'h2000_0000,
  parameter int                HEAP_BYTES = 4096,
  parameter int                GRAN_LG    = 3,
  parameter int                GRANULES   = HEAP_BYTES >> GRAN_LG,
  parameter int                IDX_W      = $clog2(GRANULES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocWrEn,
  input  logic              allocWrPriv,
  input  logic [IDX_W-1:0]  allocWrIdx,
  input  logic              allocWrVal,
  input  logic              rspValid,
  input  logic              rspIsCap,
  input  logic [DATA_W-1:0] rspData,
  input  logic              rspTag,
  output logic              outValid,
  output logic              outIsCap,
  output logic [DATA_W-1:0] outData,
  output logic              outTag
);

  revStrobe_t       strobe;
  logic [IDX_W-1:0] lookIdx;
  logic [IDX_W-1:0] wrIdx;

  revoke_ctrl #(
    .ADDR_W    (ADDR_W),
    .HEAP_BASE (HEAP_BASE),
    .HEAP_BYTES(HEAP_BYTES),
    .GRAN_LG   (GRAN_LG),
    .GRANULES  (GRANULES),
    .IDX_W     (IDX_W)
  ) uCtrl (
    .allocWrEn  (allocWrEn),
    .allocWrPriv(allocWrPriv),
    .allocWrIdx (allocWrIdx),
    .allocWrVal (allocWrVal),
    .rspValid   (rspValid),
    .rspIsCap   (rspIsCap),
    .rspAddr    (rspData[ADDR_W-1:0]),
    .strobe     (strobe),
    .lookIdx    (lookIdx),
    .wrIdx      (wrIdx)
  );

  revoke_datapath #(
    .DATA_W  (DATA_W),
    .GRANULES(GRANULES),
    .IDX_W   (IDX_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrIdx   (wrIdx),
    .lookIdx (lookIdx),
    .rspValid(rspValid),
    .rspIsCap(rspIsCap),
    .rspData (rspData),
    .rspTag  (rspTag),
    .outValid(outValid),
    .outIsCap(outIsCap),
    .outData (outData),
    .outTag  (outTag)
  );

endmodule

// File: tb/sim_cap_revoke_filter.sv
module sim_cap_revoke_filter;

  localparam longint BASE  = 64'h2000_0000;
  localparam int     BYTES = 4096;
  localparam int     GRAN  = BYTES / 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        allocWrEn, allocWrPriv, allocWrVal;
  logic [8:0]  allocWrIdx;
  logic        rspValid, rspIsCap, rspTag;
  logic [63:0] rspData;
  logic        outValid, outIsCap, outTag;
  logic [63:0] outData;

  int checks = 0;
  int fails  = 0;
  bit refMap [GRAN];

  always #10 clk = ~clk;  // 50 MHz

  cap_revoke_filter u0 (
    .clk(clk), .rstN(rstN),
    .allocWrEn(allocWrEn), .allocWrPriv(allocWrPriv),
    .allocWrIdx(allocWrIdx), .allocWrVal(allocWrVal),
    .rspValid(rspValid), .rspIsCap(rspIsCap), .rspData(rspData), .rspTag(rspTag),
    .outValid(outValid), .outIsCap(outIsCap), .outData(outData), .outTag(outTag)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input longint addr, input logic [31:0] hi);
    return {hi, addr[31:0]};
  endfunction

  // One clock: drive at negedge, model the write first, then the load, compare next negedge.
  task automatic cyc(input string req, input bit v, input bit cap, input logic [63:0] d,
                     input bit tag, input bit we, input bit priv, input int widx,
                     input bit wval);
    longint a;
    bit     inWin, expTag;
    int     idx;
    rspValid = v; rspIsCap = cap; rspData = d; rspTag = tag;
    allocWrEn = we; allocWrPriv = priv; allocWrIdx = widx[8:0]; allocWrVal = wval;
    if (we && priv && widx < GRAN) refMap[widx] = wval;
    a = longint'(d[31:0]);
    inWin = (a >= BASE) && (a < BASE + BYTES);
    idx = inWin ? int'((a - BASE) / 8) : 0;
    expTag = v && tag && !(cap && inWin && refMap[idx]);
    @(posedge clk);
    @(negedge clk);
    check(req, "outValid", 64'(outValid), 64'(v));
    check(req, "outTag", 64'(outTag), 64'(expTag));
    if (v) begin
      check(req, "outData", outData, d);
      check(req, "outIsCap", 64'(outIsCap), 64'(cap));
    end
  endtask

  task automatic load(input string req, input bit cap, input longint addr, input bit tag);
    cyc(req, 1'b1, cap, mk(addr, $urandom), tag, 1'b0, 1'b0, 0, 1'b0);
  endtask

  task automatic wr(input string req, input bit priv, input int idx, input bit val);
    cyc(req, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, priv, idx, val);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rstN = 1'b0;
    rspValid = 0; rspIsCap = 0; rspData = '0; rspTag = 0;
    allocWrEn = 0; allocWrPriv = 0; allocWrIdx = '0; allocWrVal = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "outValid in reset", 64'(outValid), 64'd0);
    check("R1", "outTag in reset", 64'(outTag), 64'd0);
    rspValid = 1; rspTag = 1; rspIsCap = 1;
    @(negedge clk);
    check("R1", "outValid in reset", 64'(outValid), 64'd0);
    rstN = 1'b1;

    // R1: all flags clear after reset
    load("R1", 1, BASE, 1);
    load("R1", 1, BASE + BYTES - 1, 1);
    // R11: idle cycle
    cyc("R11", 0, 1, 64'h0, 1, 0, 0, 0, 0);
    // R2: data patterns
    cyc("R2", 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0);
    cyc("R2", 1, 1, 64'hA5A5_5A5A_2000_0100, 1, 0, 0, 0, 0);
    // R3 / R7: revoke granule 5 (bytes 40..47)
    wr("R3", 1, 5, 1);
    load("R3", 1, BASE + 44, 1);
    load("R7", 1, BASE + 40, 1);
    load("R7", 1, BASE + 47, 1);
    load("R7", 1, BASE + 48, 1);
    load("R7", 1, BASE + 39, 1);
    // R4: tag 0 stays 0
    load("R4", 1, BASE + 44, 0);
    load("R4", 1, BASE + 200, 0);
    // R5: plain load ignores flag
    load("R5", 0, BASE + 44, 1);
    // R6: outside window, including aliases of granule 5
    wr("R6", 1, 0, 1);
    load("R6", 1, BASE - 8, 1);
    load("R6", 1, BASE + BYTES, 1);
    load("R6", 1, BASE + BYTES + 40, 1);
    load("R6", 1, BASE - BYTES + 40, 1);
    // R8: unprivileged write ignored
    wr("R8", 0, 7, 1);
    load("R8", 1, BASE + 56, 1);
    // R9: clear restores tag
    wr("R9", 1, 5, 0);
    load("R9", 1, BASE + 44, 1);
    // R10: same-cycle write-first, set and clear
    cyc("R10", 1, 1, mk(BASE + 72, 32'h1234), 1, 1, 1, 9, 1);
    load("R10", 1, BASE + 72, 1);
    cyc("R10", 1, 1, mk(BASE + 73, 32'h5678), 1, 1, 1, 9, 0);
    cyc("R10", 1, 1, mk(BASE + 8, 32'h9), 1, 1, 0, 1, 1);
    // Mixed traffic against the model (R2 R3 R6 R10)
    for (int i = 0; i < 600; i++) begin
      longint a;
      int     wi;
      a  = BASE - 32 + longint'($urandom % (BYTES + 64));
      wi = ($urandom % 3 == 0) ? int'((a - BASE) / 8) : int'($urandom % GRAN);
      if (wi < 0 || wi >= GRAN) wi = 0;
      cyc("R3", ($urandom % 5) != 0, ($urandom % 4) != 0, mk(a, $urandom),
          ($urandom % 6) != 0, ($urandom % 3) == 0, ($urandom % 5) != 0, wi,
          ($urandom % 3) != 0);
    end
    finish_run();
  end

endmodule